// File: doc/BRIEF.md
# Serial Memory Power-State Sequencer

This block follows the power state of a serial memory slave through five phases: the lockout after power-on, normal standby, the descent into sleep, sleep itself, and the climb back out. It runs on a free-running system clock. The SPI command decoder sends it two single-cycle strobes, one when a sleep command completes and one when a wake command completes. It also receives the synchronised chip-select level.

In return the block gives the command decoder three things. The first is a gated copy of chip-select. The second is a qualifier saying that every command may run. The third is a qualifier saying that only the wake command may run. It also drives a regulator-enable level for the power logic. Two sticky flags record a chip-select assertion that came too early: one for the power-on lockout and one for the wake interval.

All intervals are given in microseconds and turned into clock cycles through a cycles-per-microsecond parameter. A power loss appears as the active-low reset. It always restarts the lockout and ends in standby, whatever state the block was in before.

Top module: `pwr_seq`

## Requirements
- R1: While `rstN` is low and in the first cycle after it rises, `pwrState` is 0 (lockout), `cmdAccept` is 0, `wakeOnly` is 0, `regEn` is 1, `csFwdN` is 1, and both `startupViol` and `wakeViol` are 0.
- R2: The lockout lasts exactly STARTUP_US*CYC_PER_US clock cycles after reset is released. After that `pwrState` becomes 1 (standby) and `cmdAccept` rises to 1. `cmdAccept` is 1 only in standby.
- R3: A low `csN` in any lockout cycle is not passed on, so `csFwdN` stays 1. From the next cycle `startupViol` is 1, and it stays 1 until the next reset.
- R4: A `sleepDone` strobe in standby moves `pwrState` to 2 (entering) on the next edge. The entering state lasts ENTER_US*CYC_PER_US cycles and then becomes 3 (asleep). `regEn` is 0 only while asleep.
- R5: While entering or asleep, `wakeOnly` is 1 and `cmdAccept` is 0. A `sleepDone` strobe in either state is dropped and the state does not change.
- R6: A `wakeDone` strobe while entering or asleep moves `pwrState` to 4 (waking) on the next edge. The waking state lasts EXIT_US*CYC_PER_US cycles and then returns to standby.
- R7: A low `csN` in any waking cycle is not passed on, so `csFwdN` stays 1. From the next cycle `wakeViol` is 1, and it stays 1 until the next reset.
- R8: In standby a `wakeDone` strobe has no effect: the block stays in standby with `cmdAccept` at 1.
- R9: A reset applied while asleep leads through a full lockout to standby, never back to sleep.
- R10: In standby, entering and asleep, `csFwdN` equals `csN` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| rstN | input | 1 | Active-low power-on reset; also models a power loss |
| csN | input | 1 | Chip-select level, active low, already synchronised to `clk` |
| sleepDone | input | 1 | One-cycle strobe: a sleep command has completed |
| wakeDone | input | 1 | One-cycle strobe: a wake command has completed |
| csFwdN | output | 1 | Chip-select passed on to the command decoder, held high during lockout and waking |
| cmdAccept | output | 1 | Every command may run (standby only) |
| wakeOnly | output | 1 | Only the wake command may run (entering or asleep) |
| regEn | output | 1 | Regulator enable, low only while asleep |
| pwrState | output | 3 | 0 lockout, 1 standby, 2 entering, 3 asleep, 4 waking |
| startupViol | output | 1 | Sticky: chip-select went low during lockout |
| wakeViol | output | 1 | Sticky: chip-select went low during waking |

## Verification
The properties assume that `csN` is already synchronous to `clk`. They also assume that each done strobe is a single-cycle pulse, raised with `csN` high because a command completes on the chip-select rising edge. A strobe is never expected during lockout or waking, since the gated chip-select keeps the decoder from seeing a command then. The stimulus changes inputs only on falling clock edges. It raises strobes only with `csN` high and only in standby, entering or asleep. Random chip-select activity and dropped sleep strobes are confined to the states where they are legal. Early chip-select assertions are placed deliberately inside the lockout and waking windows.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

  typedef enum logic [2:0] {
    PS_LOCKOUT = 3'd0,
    PS_STANDBY = 3'd1,
    PS_ENTER   = 3'd2,
    PS_ASLEEP  = 3'd3,
    PS_WAKE    = 3'd4
  } pwrState_e;

  // strobes from the controller to the interval timer and the violation flags
  typedef struct packed {
    logic loadEnter;
    logic loadExit;
    logic tick;
    logic setStartViol;
    logic setWakeViol;
  } timerStrobe_t;

endpackage

// File: rtl/pwr_seq_timer.sv
module pwr_seq_timer
  import pwr_seq_pkg::*;
#(
  parameter int CNT_W     = 12,
  parameter int START_CYC = 1600,
  parameter int ENTER_CYC = 12,
  parameter int EXIT_CYC  = 1600
) (
  input  logic         clk,
  input  logic         rstN,
  input  timerStrobe_t strobe,
  output logic         expired,
  output logic         startupViol,
  output logic         wakeViol
);

  localparam logic [CNT_W-1:0] START_LD = CNT_W'(START_CYC - 1);
  localparam logic [CNT_W-1:0] ENTER_LD = CNT_W'(ENTER_CYC - 1);
  localparam logic [CNT_W-1:0] EXIT_LD  = CNT_W'(EXIT_CYC - 1);

  logic [CNT_W-1:0] remain;

  // a timed state lasts (load value + 1) cycles: it ends on the edge where remain is zero
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      remain <= START_LD;
    end else if (strobe.loadEnter) begin
      remain <= ENTER_LD;
    end else if (strobe.loadExit) begin
      remain <= EXIT_LD;
    end else if (strobe.tick && remain != '0) begin
      remain <= remain - 1'b1;
    end
  end

  assign expired = (remain == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      startupViol <= 1'b0;
      wakeViol    <= 1'b0;
    end else begin
      if (strobe.setStartViol) startupViol <= 1'b1;
      if (strobe.setWakeViol)  wakeViol    <= 1'b1;
    end
  end

endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl
  import pwr_seq_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         csN,
  input  logic         sleepDone,
  input  logic         wakeDone,
  input  logic         expired,
  output timerStrobe_t strobe,
  output pwrState_e    state,
  output logic         csFwdN,
  output logic         cmdAccept,
  output logic         wakeOnly,
  output logic         regEn
);

  pwrState_e nextState;
  logic      csBlocked;

  always_comb begin
    nextState = state;
    strobe    = '0;
    unique case (state)
      PS_LOCKOUT: begin
        strobe.tick         = 1'b1;
        strobe.setStartViol = !csN;
        if (expired) nextState = PS_STANDBY;
      end
      PS_STANDBY: begin
        if (sleepDone) begin
          nextState        = PS_ENTER;
          strobe.loadEnter = 1'b1;
        end
      end
      PS_ENTER: begin
        strobe.tick = 1'b1;
        if (wakeDone) begin
          nextState       = PS_WAKE;
          strobe.loadExit = 1'b1;
        end else if (expired) begin
          nextState = PS_ASLEEP;
        end
      end
      PS_ASLEEP: begin
        if (wakeDone) begin
          nextState       = PS_WAKE;
          strobe.loadExit = 1'b1;
        end
      end
      PS_WAKE: begin
        strobe.tick        = 1'b1;
        strobe.setWakeViol = !csN;
        if (expired) nextState = PS_STANDBY;
      end
      default: nextState = PS_LOCKOUT;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= PS_LOCKOUT;
    else       state <= nextState;
  end

  assign csBlocked = (state == PS_LOCKOUT) || (state == PS_WAKE);
  assign csFwdN    = csN | csBlocked;
  assign cmdAccept = (state == PS_STANDBY);
  assign wakeOnly  = (state == PS_ENTER) || (state == PS_ASLEEP);
  assign regEn     = (state != PS_ASLEEP);

endmodule

// File: rtl/pwr_seq.sv
module pwr_seq
  import pwr_seq_pkg::*;
#(
  parameter int CYC_PER_US = 4,
  parameter int STARTUP_US = 400,
  parameter int ENTER_US   = 3,
  parameter int EXIT_US    = 400
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       csN,
  input  logic       sleepDone,
  input  logic       wakeDone,
  output logic       csFwdN,
  output logic       cmdAccept,
  output logic       wakeOnly,
  output logic       regEn,
  output logic [2:0] pwrState,
  output logic       startupViol,
  output logic       wakeViol
);

  localparam int START_CYC = STARTUP_US * CYC_PER_US;
  localparam int ENTER_CYC = ENTER_US * CYC_PER_US;
  localparam int EXIT_CYC  = EXIT_US * CYC_PER_US;
  localparam int MAX_A     = (START_CYC > ENTER_CYC) ? START_CYC : ENTER_CYC;
  localparam int MAX_CYC   = (MAX_A > EXIT_CYC) ? MAX_A : EXIT_CYC;
  localparam int CNT_W     = $clog2(MAX_CYC + 1);

  timerStrobe_t strobe;
  pwrState_e    state;
  logic         expired;

  pwr_seq_ctrl ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .csN       (csN),
    .sleepDone (sleepDone),
    .wakeDone  (wakeDone),
    .expired   (expired),
    .strobe    (strobe),
    .state     (state),
    .csFwdN    (csFwdN),
    .cmdAccept (cmdAccept),
    .wakeOnly  (wakeOnly),
    .regEn     (regEn)
  );

  pwr_seq_timer #(
    .CNT_W     (CNT_W),
    .START_CYC (START_CYC),
    .ENTER_CYC (ENTER_CYC),
    .EXIT_CYC  (EXIT_CYC)
  ) timer_i (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .expired     (expired),
    .startupViol (startupViol),
    .wakeViol    (wakeViol)
  );

  assign pwrState = state;

endmodule

// File: rtl/pwr_seq_chk.sv
module pwr_seq_chk #(
  parameter int EXIT_CYC = 1600
) (
  input logic       clk,
  input logic       rstN,
  input logic       csN,
  input logic       sleepDone,
  input logic       wakeDone,
  input logic       csFwdN,
  input logic       cmdAccept,
  input logic       regEn,
  input logic [2:0] pwrState,
  input logic       startupViol,
  input logic       wakeViol
);

  localparam logic [2:0] S_LOCK  = 3'd0;
  localparam logic [2:0] S_STBY  = 3'd1;
  localparam logic [2:0] S_ENTER = 3'd2;
  localparam logic [2:0] S_SLEEP = 3'd3;
  localparam logic [2:0] S_WAKE  = 3'd4;

  int wakeCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  wakeCnt <= 0;
    else if (pwrState == S_WAKE) wakeCnt <= wakeCnt + 1;
    else                        wakeCnt <= 0;
  end

  assert_lock_viol_R3: assert property (@(posedge clk) disable iff (!rstN)
    (pwrState == S_LOCK && !csN) |=> startupViol);

  assert_lock_sticky_R3: assert property (@(posedge clk) disable iff (!rstN)
    startupViol |=> startupViol);

  assert_wake_viol_R7: assert property (@(posedge clk) disable iff (!rstN)
    (pwrState == S_WAKE && !csN) |=> wakeViol);

  assert_wake_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
    wakeViol |=> wakeViol);

  assert_sleep_start_R4: assert property (@(posedge clk) disable iff (!rstN)
    (pwrState == S_STBY && sleepDone) |=> pwrState == S_ENTER);

  assert_asleep_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    (pwrState == S_SLEEP && !wakeDone) |=> pwrState == S_SLEEP);

  assert_wake_start_R6: assert property (@(posedge clk) disable iff (!rstN)
    (pwrState == S_SLEEP && wakeDone) |=> pwrState == S_WAKE);

  assert_wake_short_R6: assert property (@(posedge clk) disable iff (!rstN)
    (pwrState == S_WAKE) |-> wakeCnt < EXIT_CYC);

  assert_wake_full_R6: assert property (@(posedge clk) disable iff (!rstN)
    (pwrState == S_STBY && $past(pwrState) == S_WAKE) |-> wakeCnt == EXIT_CYC);

  assert_standby_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (pwrState == S_STBY && !sleepDone) |=> (pwrState == S_STBY && cmdAccept));

  assert_fwd_gate_R10: assert property (@(posedge clk) disable iff (!rstN)
    !csFwdN |-> (!csN && pwrState != S_LOCK && pwrState != S_WAKE));

  assert_regen_R4: assert property (@(posedge clk) disable iff (!rstN)
    !regEn |-> pwrState == S_SLEEP);

endmodule

bind pwr_seq pwr_seq_chk #(.EXIT_CYC(EXIT_CYC)) chk_i (
  .clk         (clk),
  .rstN        (rstN),
  .csN         (csN),
  .sleepDone   (sleepDone),
  .wakeDone    (wakeDone),
  .csFwdN      (csFwdN),
  .cmdAccept   (cmdAccept),
  .regEn       (regEn),
  .pwrState    (pwrState),
  .startupViol (startupViol),
  .wakeViol    (wakeViol)
);

// File: tb/pwr_seq_tb_top.sv
module pwr_seq_tb_top;

  localparam int CYC   = 2;
  localparam int ST_US = 400;
  localparam int EN_US = 3;
  localparam int EX_US = 400;
  localparam int START_N = ST_US * CYC;
  localparam int ENTER_N = EN_US * CYC;
  localparam int EXIT_N  = EX_US * CYC;

  logic clk = 1'b0;
  logic rstN, csN, sleepDone, wakeDone;
  logic csFwdN, cmdAccept, wakeOnly, regEn, startupViol, wakeViol;
  logic [2:0] pwrState;

  int checks = 0;
  int errors = 0;
  int expSt  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  pwr_seq #(
    .CYC_PER_US (CYC),
    .STARTUP_US (ST_US),
    .ENTER_US   (EN_US),
    .EXIT_US    (EX_US)
  ) dut_i (
    .clk         (clk),
    .rstN        (rstN),
    .csN         (csN),
    .sleepDone   (sleepDone),
    .wakeDone    (wakeDone),
    .csFwdN      (csFwdN),
    .cmdAccept   (cmdAccept),
    .wakeOnly    (wakeOnly),
    .regEn       (regEn),
    .pwrState    (pwrState),
    .startupViol (startupViol),
    .wakeViol    (wakeViol)
  );

  function automatic int expAccept(int st);
    return (st == 1) ? 1 : 0;
  endfunction

  function automatic int expWakeOnly(int st);
    return (st == 2 || st == 3) ? 1 : 0;
  endfunction

  function automatic int expRegEn(int st);
    return (st == 3) ? 0 : 1;
  endfunction

  function automatic int expFwd(int st, logic cs);
    return (st == 0 || st == 4) ? 1 : int'(cs);
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chkAll(string req);
    chk({req, " state"}, int'(pwrState), expSt);
    chk({req, " accept"}, int'(cmdAccept), expAccept(expSt));
    chk({req, " wakeOnly"}, int'(wakeOnly), expWakeOnly(expSt));
    chk({req, " regEn"}, int'(regEn), expRegEn(expSt));
    chk({req, " csFwdN"}, int'(csFwdN), expFwd(expSt, csN));
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulseSleep();
    sleepDone = 1'b1;
    tick(1);
    sleepDone = 1'b0;
  endtask

  task automatic pulseWake();
    wakeDone = 1'b1;
    tick(1);
    wakeDone = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    rstN = 1'b0; csN = 1'b1; sleepDone = 1'b0; wakeDone = 1'b0;
    tick(3);
    expSt = 0;
    chkAll("R1 in reset");
    chk("R1 startupViol", int'(startupViol), 0);
    chk("R1 wakeViol", int'(wakeViol), 0);

    // lockout timing
    rstN = 1'b1;
    tick(START_N - 1);
    chkAll("R2 lockout last cycle");
    tick(1);
    expSt = 1;
    chkAll("R2 standby reached");
    chk("R3 no lockout viol", int'(startupViol), 0);

    // random chip-select activity and stray wake strobes in standby
    for (int i = 0; i < 40; i++) begin
      csN = 1'($urandom_range(0, 1));
      if ($urandom_range(0, 3) == 0 && csN) pulseWake();
      else tick(1);
      chkAll("R8 R10 standby random");
    end
    csN = 1'b1;

    // sleep entry
    pulseSleep();
    expSt = 2;
    chkAll("R4 entering");
    tick(ENTER_N - 1);
    chkAll("R4 entering last cycle");
    tick(1);
    expSt = 3;
    chkAll("R4 asleep");

    // random traffic while asleep: sleep strobes dropped
    for (int i = 0; i < 40; i++) begin
      csN = 1'($urandom_range(0, 1));
      if ($urandom_range(0, 2) == 0 && csN) pulseSleep();
      else tick(1);
      chkAll("R5 R10 asleep random");
    end
    csN = 1'b1;

    // wake with an early chip-select inside the window
    pulseWake();
    expSt = 4;
    chkAll("R6 waking");
    chk("R7 no wake viol yet", int'(wakeViol), 0);
    tick(10);
    csN = 1'b0;
    chk("R7 csFwdN blocked", int'(csFwdN), 1);
    tick(1);
    chk("R7 wake viol set", int'(wakeViol), 1);
    csN = 1'b1;
    tick(EXIT_N - 12);
    chkAll("R6 waking last cycle");
    tick(1);
    expSt = 1;
    chkAll("R6 standby after wake");
    chk("R7 wake viol sticky", int'(wakeViol), 1);
    chk("R3 lockout flag untouched", int'(startupViol), 0);

    // wake during entry
    pulseSleep();
    expSt = 2;
    tick(2);
    chkAll("R5 entering");
    pulseSleep();
    chkAll("R5 sleep strobe dropped while entering");
    pulseWake();
    expSt = 4;
    chkAll("R6 wake from entering");
    tick(EXIT_N - 1);
    chkAll("R6 waking last cycle 2");
    tick(1);
    expSt = 1;
    chkAll("R6 standby 2");

    // power loss while asleep
    pulseSleep();
    tick(ENTER_N);
    expSt = 3;
    chkAll("R9 asleep before loss");
    rstN = 1'b0;
    tick(2);
    expSt = 0;
    chkAll("R9 R1 reset while asleep");
    chk("R1 wakeViol cleared", int'(wakeViol), 0);
    rstN = 1'b1;
    tick(5);
    csN = 1'b0;
    chk("R3 csFwdN blocked", int'(csFwdN), 1);
    tick(1);
    chk("R3 lockout viol set", int'(startupViol), 1);
    csN = 1'b1;
    tick(START_N - 7);
    chkAll("R9 lockout last cycle");
    tick(1);
    expSt = 1;
    chkAll("R9 standby after loss");
    chk("R3 lockout viol sticky", int'(startupViol), 1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule